// File: doc/BRIEF.md
# Multi-Mode Timer Channel

One 16-bit down/up counting channel that is programmed through three small write-only registers. A two-bit mode picks one of four behaviours: a free-running periodic timer, a counter of edges on an external pin, a one-shot delay started by a trigger, or a pulse-width generator with a fixed period. The counting rate comes from one of four clock enables. The fourth enable is made by an internal divide-by-32 prescaler that runs on a slow subclock enable. The external pin is cleaned by a sampling noise filter before it is used as an event or as a trigger. The channel raises a one-cycle interrupt pulse at each underflow, at the end of each one-shot run and at each end of a PWM period.

Software writes the mode register first, then the reload value, then the control register, which holds the start bit and the trigger choice. The channel has no streaming data path, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level or single-cycle pulse, sampled on the rising clock edge. One register write is accepted per cycle.

Top module: `mm_timer_chan`

## Requirements
- R1: After reset `count_val` is 0, `pwm_out` is 0 and `irq` is 0.
- R2: Mode register (`wr_sel`=0) bits [3:2] pick the count source: 00 `tick_full`, 01 `tick_div8`, 10 `tick_div2n`, 11 the prescaled subclock. An enable that is not selected has no effect on the count.
- R3: The prescaler passes one enable for every 32 `tick_sub` enables while `presc_run` is 1. While `presc_run` is 0 it is held cleared, so the first prescaled enable comes at the 32nd `tick_sub` enable after `presc_run` rises.
- R4: Mode bits [1:0]=00 (timer): on each selected enable the count decreases by one. An enable at count 0 reloads the reload value and pulses `irq` for one cycle, so the period is reload+1 enables.
- R5: A reload write (`wr_sel`=1) made while stopped in a mode other than PWM also loads the counter in the next cycle. A reload write made while running first takes effect at the next reload.
- R6: Clearing the start bit (control register, `wr_sel`=2, bit 0) freezes the count at its current value. Setting it again resumes counting from that value.
- R7: The noise filter samples `ext_pin` on each selected enable and accepts a new level only when three consecutive samples agree. A pulse shorter than three enables is ignored.
- R8: Mode 01 (event counter): each accepted rising edge of the filtered pin decreases the count by one. An edge at count 0 reloads and pulses `irq`. Falling edges do not count.
- R9: Mode 10 (one-shot): a trigger loads the reload value. The count then decreases on each enable, and the enable at 0 pulses `irq` and stops the run, with the count held at 0 until the next trigger.
- R10: Control bits [2:1] pick the trigger for one-shot and PWM: 00 the start bit going from 0 to 1, 01 a filtered rising edge, 10 a filtered falling edge, 11 a `nbr_flow` pulse. A trigger that does not match the selected kind is ignored.
- R11: Mode 11 (PWM): after a trigger, `count_val` counts 0 to 2^CNT_W-1 and wraps. `pwm_out` is high while the count is below the duty value. At each wrap `irq` pulses and the latest reload value becomes the new duty value; a reload write made mid-period does not change the current period.
- R12: Writing the mode register ends any one-shot or PWM run and clears the count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_full | input | 1 | Count enable at the full rate |
| tick_div8 | input | 1 | Count enable at one eighth of the rate |
| tick_div2n | input | 1 | Count enable from a programmable even divider |
| tick_sub | input | 1 | Subclock enable fed to the divide-by-32 prescaler |
| presc_run | input | 1 | Prescaler run control; 0 holds it cleared |
| ext_pin | input | 1 | External event/trigger pin, synchronous to clk |
| nbr_flow | input | 1 | Underflow/overflow pulse from a neighbouring channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 reload, 2 control |
| wr_data | input | CNT_W | Register write data |
| count_val | output | CNT_W | Current count or PWM phase |
| pwm_out | output | 1 | Pulse-width output |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The timer mode runs with a short reload, is frozen mid-count, then resumes with a reload rewritten in flight, which tells an immediate reload apart from a deferred one. The pin is driven first with a two-enable glitch, then with long pulses, so filter rejection, event counting and the two edge directions are each seen on their own. The one-shot is started once by each trigger kind, by a start rise, a neighbour pulse and a pin edge, and the timing of each interrupt shows which trigger won. PWM runs two full periods with a duty change in the first, and the number of high cycles counted in each period shows whether the change was held back to the boundary. The prescaler is held, then released, and the first interrupt shows that its phase starts from zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_TIMER   = 2'd0,
    MD_EVENT   = 2'd1,
    MD_ONESHOT = 2'd2,
    MD_PWM     = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_FULL  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV2N = 2'd2,
    SRC_SUB   = 2'd3
  } tmr_src_e;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_NBR  = 2'd3
  } tmr_trig_e;

  localparam logic [1:0] A_MODE   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
endpackage

// File: rtl/tmr_cfg.sv
module tmr_cfg
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output tmr_mode_e    mode_q,
  output tmr_src_e     src_q,
  output tmr_trig_e    trig_q,
  output logic         start_q,
  output logic [W-1:0] reload_q,
  output logic         mode_wr,
  output logic         reload_wr
);
  logic ctrl_wr;

  assign mode_wr   = wr_en && (wr_sel == A_MODE);
  assign reload_wr = wr_en && (wr_sel == A_RELOAD);
  assign ctrl_wr   = wr_en && (wr_sel == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MD_TIMER;
      src_q    <= SRC_FULL;
      trig_q   <= TRG_SOFT;
      start_q  <= 1'b0;
      reload_q <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= tmr_mode_e'(wr_data[1:0]);
        src_q  <= tmr_src_e'(wr_data[3:2]);
      end
      if (reload_wr) reload_q <= wr_data;
      if (ctrl_wr) begin
        start_q <= wr_data[0];
        trig_q  <= tmr_trig_e'(wr_data[2:1]);
      end
    end
  end
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
#(
  parameter int PRESC_DIV = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_src_e src_sel,
  input  logic     tick_full,
  input  logic     tick_div8,
  input  logic     tick_div2n,
  input  logic     tick_sub,
  input  logic     presc_run,
  output logic     tick
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic       sub_tick;
  logic [3:0] en_vec;

  generate
    if (PRESC_DIV > 1) begin : g_presc
      localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || !presc_run) pcnt_q <= '0;
        else if (tick_sub) pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
      end

      assign sub_tick = tick_sub && (pcnt_q == LAST);

      // R3: a prescaler held off for two cycles passes no enable
      p_presc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!presc_run ##1 !presc_run) |-> !sub_tick)
        else $error("prescaler produced an enable while held");
    end else begin : g_bypass
      assign sub_tick = tick_sub && presc_run;
    end
  endgenerate

  assign en_vec = {sub_tick, tick_div2n, tick_div8, tick_full};
  assign tick   = en_vec[src_sel];
endmodule

// File: rtl/tmr_noise_filt.sv
module tmr_noise_filt #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic level_q,
  output logic rise_q,
  output logic fall_q
);
  localparam int HW = (LEN > 1) ? LEN - 1 : 1;

  logic [HW-1:0] hist_q;
  logic          agree;

  assign agree = (hist_q == {HW{pin}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q  <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (tick) begin
        hist_q <= HW'({hist_q, pin});
        if (agree && (pin != level_q)) begin
          level_q <= pin;
          rise_q  <= pin;
          fall_q  <= !pin;
        end
      end
    end
  end

  // R7: the accepted level never moves between enables
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q))
    else $error("filter level moved without an enable");

  // R7: an edge pulse always agrees with the level it reports
  p_edge_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q |-> level_q) and (fall_q |-> !level_q))
    else $error("filter edge pulse disagrees with level");
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tmr_mode_e    mode_q,
  input  tmr_trig_e    trig_q,
  input  logic         start_q,
  input  logic [W-1:0] reload_q,
  input  logic [W-1:0] wr_val,
  input  logic         mode_wr,
  input  logic         reload_wr,
  input  logic         ev_rise,
  input  logic         ev_fall,
  input  logic         nbr_flow,
  output logic [W-1:0] cnt_q,
  output logic         pwm_out,
  output logic         irq_q
);
  localparam logic [W-1:0] PMAX = '1;

  logic         start_d;
  logic         active_q;
  logic [W-1:0] duty_q;
  logic         trig_hit;

  always_comb begin
    unique case (trig_q)
      TRG_SOFT: trig_hit = start_q && !start_d;
      TRG_RISE: trig_hit = ev_rise;
      TRG_FALL: trig_hit = ev_fall;
      default:  trig_hit = nbr_flow;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      duty_q   <= '0;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      start_d  <= 1'b0;
    end else begin
      start_d <= start_q;
      irq_q   <= 1'b0;
      if (mode_wr) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (reload_wr && !start_q && (mode_q != MD_PWM)) begin
        cnt_q <= wr_val;
      end else if (start_q) begin
        unique case (mode_q)
          MD_TIMER, MD_EVENT: begin
            if ((mode_q == MD_TIMER) ? tick : ev_rise) begin
              if (cnt_q == '0) begin
                cnt_q <= reload_q;
                irq_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end
          MD_ONESHOT: begin
            if (!active_q) begin
              if (trig_hit) begin
                active_q <= 1'b1;
                cnt_q    <= reload_q;
              end
            end else if (tick) begin
              if (cnt_q == '0) begin
                active_q <= 1'b0;
                irq_q    <= 1'b1;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end
          default: begin
            if (!active_q) begin
              if (trig_hit) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                duty_q   <= reload_q;
              end
            end else if (tick) begin
              if (cnt_q == PMAX) begin
                cnt_q  <= '0;
                duty_q <= reload_q;
                irq_q  <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign pwm_out = (mode_q == MD_PWM) && active_q && (cnt_q < duty_q);

  // R4: an enable at zero in timer mode reloads and raises the request
  p_uf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TIMER && start_q && tick && cnt_q == '0 && !mode_wr)
      |=> (cnt_q == $past(reload_q)) && irq_q)
    else $error("timer underflow did not reload");

  // R6: a stopped channel keeps its count unless software writes it
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !mode_wr && !reload_wr) |=> $stable(cnt_q))
    else $error("count moved while stopped");

  // R9: a one-shot request comes with the run already ended
  p_oneshot_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && irq_q) |-> !active_q)
    else $error("one-shot still active after its request");

  // R11: duty only changes at a period wrap
  p_duty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PWM && active_q && !(start_q && tick && cnt_q == PMAX))
      |=> $stable(duty_q))
    else $error("duty changed inside a period");
endmodule

// File: rtl/mm_timer_chan.sv
module mm_timer_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FILT_LEN  = 3,
  parameter int PRESC_DIV = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_full,
  input  logic             tick_div8,
  input  logic             tick_div2n,
  input  logic             tick_sub,
  input  logic             presc_run,
  input  logic             ext_pin,
  input  logic             nbr_flow,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_val,
  output logic             pwm_out,
  output logic             irq
);
  tmr_mode_e        mode_q;
  tmr_src_e         src_q;
  tmr_trig_e        trig_q;
  logic             start_q;
  logic [CNT_W-1:0] reload_q;
  logic             mode_wr;
  logic             reload_wr;
  logic             tick;
  logic             pin_level;
  logic             pin_rise;
  logic             pin_fall;

  tmr_cfg #(.W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .mode_q    (mode_q),
    .src_q     (src_q),
    .trig_q    (trig_q),
    .start_q   (start_q),
    .reload_q  (reload_q),
    .mode_wr   (mode_wr),
    .reload_wr (reload_wr)
  );

  tmr_src_sel #(.PRESC_DIV(PRESC_DIV)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_q),
    .tick_full  (tick_full),
    .tick_div8  (tick_div8),
    .tick_div2n (tick_div2n),
    .tick_sub   (tick_sub),
    .presc_run  (presc_run),
    .tick       (tick)
  );

  tmr_noise_filt #(.LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pin     (ext_pin),
    .level_q (pin_level),
    .rise_q  (pin_rise),
    .fall_q  (pin_fall)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode_q    (mode_q),
    .trig_q    (trig_q),
    .start_q   (start_q),
    .reload_q  (reload_q),
    .wr_val    (wr_data),
    .mode_wr   (mode_wr),
    .reload_wr (reload_wr),
    .ev_rise   (pin_rise),
    .ev_fall   (pin_fall),
    .nbr_flow  (nbr_flow),
    .cnt_q     (count_val),
    .pwm_out   (pwm_out),
    .irq_q     (irq)
  );

  // R12: a mode write leaves a zero count behind it
  p_mode_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (count_val == '0) && !pwm_out)
    else $error("mode write did not clear the channel");

  // R1: no request while the filtered level is idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (count_val == '0) && !irq && !pin_level)
    else $error("reset state wrong");
endmodule

// File: tb/test_mm_timer_chan.sv
module test_mm_timer_chan;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         tick_full, tick_div8, tick_div2n, tick_sub, presc_run;
  logic         ext_pin, nbr_flow;
  logic         wr_en;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic [W-1:0] count_val;
  logic         pwm_out;
  logic         irq;

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  int    exp_q[$];
  string tag_q[$];
  int    base;
  int    hi1, hi2;

  mm_timer_chan #(.CNT_W(W)) i_mm_timer_chan (
    .clk(clk), .rst_n(rst_n),
    .tick_full(tick_full), .tick_div8(tick_div8), .tick_div2n(tick_div2n),
    .tick_sub(tick_sub), .presc_run(presc_run),
    .ext_pin(ext_pin), .nbr_flow(nbr_flow),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_val(count_val), .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_irq(input int at, input string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
  endtask

  // one register write; starts and ends on a falling edge
  task automatic wr(input logic [1:0] sel, input int d);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: every request must match the head of the expectation queue
  always @(negedge clk) begin
    if (rst_n && irq) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected irq: actual=cycle %0d expected=none", cyc);
      end else begin
        if (exp_q[0] != cyc) begin
          bad++;
          $display("FAIL %s irq: actual=cycle %0d expected=cycle %0d", tag_q[0], cyc, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; tick_full = 1; tick_div8 = 0; tick_div2n = 0; tick_sub = 0;
    presc_run = 0; ext_pin = 0; nbr_flow = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", int'(count_val), 0);
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 irq", int'(irq), 0);

    // R2: divide-by-8 selected with that enable held low
    wr(2'd0, 'b0100);
    wr(2'd1, 5);
    chk("R5 stopped load", int'(count_val), 5);
    wr(2'd2, 1);
    repeat (6) @(negedge clk);
    chk("R2 unselected enable", int'(count_val), 5);
    wr(2'd2, 0);

    // R4 timer mode, reload 3
    wr(2'd0, 'b0000);
    wr(2'd1, 3);
    chk("R5 stopped load", int'(count_val), 3);
    wr(2'd2, 1);
    base = cyc;
    expect_irq(base + 4, "R4");
    expect_irq(base + 8, "R4");
    wait_until(base + 2);
    chk("R4 countdown", int'(count_val), 1);
    wait_until(base + 9);
    wr(2'd2, 0);
    repeat (5) @(negedge clk);
    chk("R6 frozen", int'(count_val), 1);
    wr(2'd2, 1);
    base = cyc;
    wr(2'd1, 6);
    expect_irq(base + 2, "R6 resume");
    expect_irq(base + 9, "R5 running reload");
    wait_until(base + 3);
    chk("R5 running reload", int'(count_val), 5);
    wait_until(base + 10);
    wr(2'd2, 0);

    // R3 prescaled subclock
    wr(2'd0, 'b1100);
    wr(2'd1, 1);
    tick_sub = 1;
    wr(2'd2, 1);
    repeat (40) @(negedge clk);
    chk("R3 prescaler held", int'(count_val), 1);
    presc_run = 1;
    base = cyc;
    expect_irq(base + 64, "R3");
    wait_until(base + 70);
    chk("R3 after first wrap", int'(count_val), 1);
    wr(2'd2, 0);
    presc_run = 0;
    tick_sub = 0;

    // R7 / R8 event counter through the filter
    wr(2'd0, 'b0001);
    wr(2'd1, 1);
    wr(2'd2, 1);
    ext_pin = 1;
    repeat (2) @(negedge clk);
    ext_pin = 0;
    repeat (5) @(negedge clk);
    chk("R7 glitch ignored", int'(count_val), 1);
    ext_pin = 1;
    repeat (6) @(negedge clk);
    chk("R8 one event", int'(count_val), 0);
    ext_pin = 0;
    repeat (6) @(negedge clk);
    chk("R8 fall not counted", int'(count_val), 0);
    ext_pin = 1;
    expect_irq(cyc + 4, "R8");
    repeat (6) @(negedge clk);
    ext_pin = 0;
    repeat (6) @(negedge clk);
    chk("R8 reloaded", int'(count_val), 1);

    // R9 / R10 one-shot with each trigger kind
    wr(2'd2, 0);
    wr(2'd0, 'b0010);
    wr(2'd1, 2);
    wr(2'd2, 'b001);
    base = cyc;
    expect_irq(base + 4, "R10 soft trigger");
    wait_until(base + 8);
    chk("R9 stopped at zero", int'(count_val), 0);
    wr(2'd2, 'b111);
    repeat (3) @(negedge clk);
    chk("R10 no start rise", int'(count_val), 0);
    nbr_flow = 1;
    base = cyc;
    expect_irq(base + 4, "R10 neighbour trigger");
    @(negedge clk);
    nbr_flow = 0;
    wait_until(base + 2);
    chk("R9 countdown", int'(count_val), 1);
    repeat (6) @(negedge clk);
    wr(2'd2, 'b011);
    ext_pin = 1;
    expect_irq(cyc + 7, "R10 rising trigger");
    repeat (8) @(negedge clk);
    ext_pin = 0;
    repeat (8) @(negedge clk);
    chk("R10 falling edge ignored", int'(count_val), 0);

    // R11 PWM over two periods of 2^W
    wr(2'd2, 0);
    wr(2'd0, 'b0011);
    chk("R12 mode write clears", int'(count_val), 0);
    wr(2'd1, 3);
    wr(2'd2, 1);
    base = cyc;
    expect_irq(base + 257, "R11 period end");
    expect_irq(base + 513, "R11 period end");
    hi1 = 0;
    hi2 = 0;
    for (int i = 1; i <= 512; i++) begin
      @(negedge clk);
      if (i == 5) chk("R11 phase", int'(count_val), 4);
      if (pwm_out) begin
        if (i <= 256) hi1++;
        else hi2++;
      end
      if (i == 10) begin
        wr_en = 1; wr_sel = 2'd1; wr_data = W'(5);
      end
      if (i == 11) wr_en = 0;
    end
    chk("R11 first period high", hi1, 3);
    chk("R11 second period high", hi2, 5);
    wr(2'd2, 0);
    repeat (4) @(negedge clk);

    chk("R4 all requests seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule